// File: doc/BRIEF.md
# Circular log address controller

This block drives wear-levelled sequential logging into a byte-addressable non-volatile memory through a plain byte-wide port with read, write, address, data and ready signals. The memory is split into 256-byte pages. The top page holds nothing but session metadata. Every other page forms a circular data area. Each session carries on from the place where the previous session stopped, so no single region takes all the writes.

A session opens on a start request. The block reads the metadata bytes from the reserved page and takes the stored write position as its starting point. It then stores each byte the producer offers at successive addresses, and wraps from the end of the data area back to address 0. The reserved page is never part of the data area. An end request makes the block write three fields back into the reserved page: where readback begins, where the next session writes, and how many bytes the session holds. A replay request reads the metadata and streams the latest session's bytes out in the order they were written.

Top module: `circ_log_ctrl`

## Requirements
- R1: After reset, `idle` is 1, and `log_ready`, `out_valid`, `mem_rd` and `mem_wr` are all 0.
- R2: An accepted start request reads the reserved page bytes at offsets 0 through 8, in ascending order. The reserved page starts at address 2^ADDR_W − 256. `log_ready` rises only after all nine reads are done.
- R3: The metadata is nine bytes, and each 3-byte field is stored most significant byte first. Offsets 0–2 hold the read-start address, offsets 3–5 the write-start address and offsets 6–8 the byte count. A field whose bytes are all 0xFF counts as never written. When the write-start field is never written, the first logged byte goes to address 0.
- R4: When a valid write-start address is stored, the session's first byte goes to that address. Each later byte goes to the address one higher than the byte before it.
- R5: The next address after the last byte of the page just below the reserved page is address 0. Logged data is never written into the reserved page. Only the metadata write-back touches that page.
- R6: An end request writes the three fields into offsets 0–8 of the reserved page. The read-start field is the session's first address. The write-start field is the address after the last byte written, with the wrap of R5 applied. The count field is the number of bytes written in the session.
- R7: The session count saturates at the data-area size, 2^ADDR_W − 256 bytes. The oldest bytes are then overwritten, and the stored read-start equals the stored write-start.
- R8: A replay request reads the metadata and then emits exactly `count` bytes on `out_data`, one `out_valid` pulse per byte. The bytes start at the read-start address and follow the wrap of R5. After the last byte, `idle` returns to 1.
- R9: A replay whose count field is never written emits no byte and returns to idle without writing memory.
- R10: Start and replay requests are accepted only in idle, and end requests only while a session waits for data. A request at any other time causes no memory access and no change of state.
- R11: `mem_rd` and `mem_wr` are never both high. Once a request is raised, its type, address and write data stay unchanged until the cycle in which `mem_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | Open a logging session (idle only) |
| end_req | input | 1 | Close the session and store metadata |
| replay_req | input | 1 | Stream back the latest session (idle only) |
| log_valid | input | 1 | Producer offers a byte |
| log_data | input | 8 | Byte to log |
| log_ready | output | 1 | Session open and able to take a byte |
| out_valid | output | 1 | One-cycle pulse: replayed byte on out_data |
| out_data | output | 8 | Replayed byte |
| idle | output | 1 | No session, replay or memory access in progress |
| mem_rd | output | 1 | Memory read request, held until ready |
| mem_wr | output | 1 | Memory write request, held until ready |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid with mem_ready |
| mem_ready | input | 1 | Access complete in this cycle |

## Verification
The hardest cases to reach from the ports are the wrap past the reserved page and count saturation. Both normally need a nearly full data area. The bench therefore writes metadata straight into its memory model, placing the write start a few bytes below the reserved page. Counting up from a fresh device would take far longer. For saturation, the bench logs slightly more bytes than the data area holds. It then checks that replay returns exactly the newest bytes, starting at the stored write position.

// File: rtl/clog_pkg.sv
// Shared types and fixed metadata geometry for the circular log controller.
// Assumes three metadata fields, each three bytes wide.
package clog_pkg;
    localparam int FIELD_BYTES = 3;
    localparam int N_FIELDS    = 3;
    localparam int FIELD_W     = FIELD_BYTES * 8;
    localparam int META_BYTES  = FIELD_BYTES * N_FIELDS;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_DECIDE,
        S_OPEN,
        S_WRITE,
        S_STORE,
        S_RPLY
    } clog_state_t;
endpackage

// File: rtl/clog_addr_step.sv
// Next data address with the reserved-page skip.
// Past the last data byte the address goes back to zero, which is the same
// as adding one page and wrapping modulo the memory size.
// Assumes the input is a valid data-area address.
module clog_addr_step #(
    parameter int ADDR_W = 17,
    parameter int PAGE_W = 8
) (
    input  logic [ADDR_W-1:0] addr_cur,
    output logic [ADDR_W-1:0] addr_nxt
);
    localparam logic [ADDR_W-1:0] LAST_A =
        ADDR_W'((1 << ADDR_W) - (1 << PAGE_W) - 1);

    // Increment, or jump over the reserved page back to zero.
    always_comb begin
        if (addr_cur >= LAST_A) addr_nxt = '0;
        else                    addr_nxt = addr_cur + 1'b1;
    end
endmodule

// File: rtl/clog_meta_sreg.sv
// Metadata shift register, used in both directions.
// Bytes read from the reserved page shift in at the bottom, most significant
// first. For write-back the fields load in parallel and leave from the top.
// Each field has an all-ones flag that marks it as never written.
// Assumes field 0 (the read start) sits in the top bits.
module clog_meta_sreg #(
    parameter int FIELD_W  = 24,
    parameter int N_FIELDS = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load_par,
    input  logic [N_FIELDS*FIELD_W-1:0] par_in,
    input  logic                        shift_in_en,
    input  logic [7:0]                  byte_in,
    input  logic                        shift_out_en,
    output logic [7:0]                  byte_out,
    output logic [N_FIELDS*FIELD_W-1:0] fields,
    output logic [N_FIELDS-1:0]         blank
);
    localparam int TOT_W = N_FIELDS * FIELD_W;

    logic [TOT_W-1:0] sreg;

    // Parallel load for write-back, byte shifts for read-in and write-out.
    always_ff @(posedge clk) begin
        if (!rst_n)            sreg <= '1;
        else if (load_par)     sreg <= par_in;
        else if (shift_in_en)  sreg <= {sreg[TOT_W-9:0], byte_in};
        else if (shift_out_en) sreg <= {sreg[TOT_W-9:0], 8'hFF};
    end

    assign byte_out = sreg[TOT_W-1 -: 8];
    assign fields   = sreg;

    // One never-written flag per field.
    for (genvar g = 0; g < N_FIELDS; g++) begin : g_blank
        assign blank[g] = &sreg[g*FIELD_W +: FIELD_W];
    end
endmodule

// File: rtl/clog_sat_count.sv
// Saturating up-counter for the session byte count.
// It clears when a session opens and stops at LIMIT.
module clog_sat_count #(
    parameter int W     = 24,
    parameter int LIMIT = 130816
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         full
);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    assign full = (cnt == LIM);

    // Count written bytes, holding at the data-area size.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)   cnt <= '0;
        else if (inc && !full) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/circ_log_ctrl.sv
// Circular log address controller (top).
// Loads session metadata from the reserved top page, appends producer bytes
// from the stored write position with wrap-around, writes the metadata back
// when the session ends, and replays the latest session on request.
// Assumes one memory access at a time, each completed by a mem_ready cycle,
// and ADDR_W no wider than a metadata field.
module circ_log_ctrl #(
    parameter int ADDR_W = 17,
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              end_req,
    input  logic              replay_req,
    input  logic              log_valid,
    input  logic [7:0]        log_data,
    output logic              log_ready,
    output logic              out_valid,
    output logic [7:0]        out_data,
    output logic              idle,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_ready
);
    import clog_pkg::*;

    localparam int MEM_BYTES  = 1 << ADDR_W;
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int DATA_BYTES = MEM_BYTES - PAGE_BYTES;
    localparam int IDX_W      = $clog2(META_BYTES);
    localparam logic [ADDR_W-1:0]  RES_BASE = ADDR_W'(DATA_BYTES);
    localparam logic [FIELD_W-1:0] DATA_F   = FIELD_W'(DATA_BYTES);
    localparam logic [FIELD_W-1:0] LAST_F   = FIELD_W'(DATA_BYTES - 1);
    localparam logic [IDX_W-1:0]   IDX_LAST = IDX_W'(META_BYTES - 1);

    clog_state_t         state;
    logic                for_replay;
    logic [IDX_W-1:0]    idx;
    logic [ADDR_W-1:0]   wptr, sess_start, rptr;
    logic [ADDR_W-1:0]   w_nxt, r_nxt;
    logic [FIELD_W-1:0]  remain;
    logic [7:0]          wbyte;
    logic                out_valid_q;
    logic [7:0]          out_data_q;

    logic [N_FIELDS*FIELD_W-1:0] fields;
    logic [N_FIELDS-1:0]         blank;
    logic [FIELD_W-1:0]          f_rs, f_ws, f_cnt;
    logic [7:0]                  meta_byte;
    logic                        sreg_load, sreg_in, sreg_out;
    logic [ADDR_W-1:0]           rs_out;
    logic [ADDR_W-1:0]           ws_addr, rs_addr;
    logic [FIELD_W-1:0]          cnt_eff;

    logic [FIELD_W-1:0] sess_cnt;
    logic               cnt_full;
    logic               cnt_clr, cnt_inc;

    // Address steppers for the write and read pointers.
    clog_addr_step #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_wstep (
        .addr_cur (wptr),
        .addr_nxt (w_nxt)
    );
    clog_addr_step #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_rstep (
        .addr_cur (rptr),
        .addr_nxt (r_nxt)
    );

    assign sreg_in   = (state == S_LOAD)  && mem_ready;
    assign sreg_out  = (state == S_STORE) && mem_ready;
    assign sreg_load = (state == S_OPEN)  && end_req && !log_valid;
    assign rs_out    = cnt_full ? wptr : sess_start;

    clog_meta_sreg #(.FIELD_W(FIELD_W), .N_FIELDS(N_FIELDS)) u_meta (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_par     (sreg_load),
        .par_in       ({FIELD_W'(rs_out), FIELD_W'(wptr), sess_cnt}),
        .shift_in_en  (sreg_in),
        .byte_in      (mem_rdata),
        .shift_out_en (sreg_out),
        .byte_out     (meta_byte),
        .fields       (fields),
        .blank        (blank)
    );

    assign f_rs  = fields[3*FIELD_W-1 -: FIELD_W];
    assign f_ws  = fields[2*FIELD_W-1 -: FIELD_W];
    assign f_cnt = fields[FIELD_W-1:0];

    assign cnt_clr = (state == S_DECIDE) && !for_replay;
    assign cnt_inc = (state == S_WRITE) && mem_ready;

    clog_sat_count #(.W(FIELD_W), .LIMIT(DATA_BYTES)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .cnt   (sess_cnt),
        .full  (cnt_full)
    );

    // Turn loaded fields into usable values: blank or out-of-range means zero.
    always_comb begin
        ws_addr = (!blank[1] && f_ws <= LAST_F) ? f_ws[ADDR_W-1:0] : '0;
        rs_addr = (!blank[2] && f_rs <= LAST_F) ? f_rs[ADDR_W-1:0] : '0;
        if (blank[0])          cnt_eff = '0;
        else if (f_cnt > DATA_F) cnt_eff = DATA_F;
        else                   cnt_eff = f_cnt;
    end

    // Memory request, derived from the state and held until ready.
    always_comb begin
        mem_rd    = (state == S_LOAD) || (state == S_RPLY);
        mem_wr    = (state == S_WRITE) || (state == S_STORE);
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            S_LOAD:  mem_addr = RES_BASE + ADDR_W'(idx);
            S_STORE: begin
                mem_addr  = RES_BASE + ADDR_W'(idx);
                mem_wdata = meta_byte;
            end
            S_WRITE: begin
                mem_addr  = wptr;
                mem_wdata = wbyte;
            end
            S_RPLY:  mem_addr = rptr;
            default: ;
        endcase
    end

    // Sequencing of sessions, metadata transfers and replay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= S_IDLE;
            for_replay  <= 1'b0;
            idx         <= '0;
            wptr        <= '0;
            sess_start  <= '0;
            rptr        <= '0;
            remain      <= '0;
            wbyte       <= '0;
            out_valid_q <= 1'b0;
            out_data_q  <= '0;
        end else begin
            out_valid_q <= 1'b0;
            case (state)
                S_IDLE: begin
                    idx <= '0;
                    if (start_req) begin
                        for_replay <= 1'b0;
                        state      <= S_LOAD;
                    end else if (replay_req) begin
                        for_replay <= 1'b1;
                        state      <= S_LOAD;
                    end
                end
                S_LOAD: begin
                    if (mem_ready) begin
                        if (idx == IDX_LAST) begin
                            idx   <= '0;
                            state <= S_DECIDE;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                S_DECIDE: begin
                    if (for_replay) begin
                        rptr   <= rs_addr;
                        remain <= cnt_eff;
                        state  <= (cnt_eff == '0) ? S_IDLE : S_RPLY;
                    end else begin
                        wptr       <= ws_addr;
                        sess_start <= ws_addr;
                        state      <= S_OPEN;
                    end
                end
                S_OPEN: begin
                    if (log_valid) begin
                        wbyte <= log_data;
                        state <= S_WRITE;
                    end else if (end_req) begin
                        idx   <= '0;
                        state <= S_STORE;
                    end
                end
                S_WRITE: begin
                    if (mem_ready) begin
                        wptr  <= w_nxt;
                        state <= S_OPEN;
                    end
                end
                S_STORE: begin
                    if (mem_ready) begin
                        if (idx == IDX_LAST) state <= S_IDLE;
                        else                 idx   <= idx + 1'b1;
                    end
                end
                S_RPLY: begin
                    if (mem_ready) begin
                        out_valid_q <= 1'b1;
                        out_data_q  <= mem_rdata;
                        rptr        <= r_nxt;
                        remain      <= remain - 1'b1;
                        if (remain == FIELD_W'(1)) state <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign log_ready = (state == S_OPEN);
    assign idle      = (state == S_IDLE);
    assign out_valid = out_valid_q;
    assign out_data  = out_data_q;
endmodule

// File: rtl/clog_checker.sv
// Property checker for the circular log controller, bound to the top.
// Watches the memory handshake, protection of the reserved page, the count
// cap and the replay output.
module clog_checker #(
    parameter int ADDR_W = 17,
    parameter int PAGE_W = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       mem_rd,
    input logic                       mem_wr,
    input logic [ADDR_W-1:0]          mem_addr,
    input logic [7:0]                 mem_wdata,
    input logic                       mem_ready,
    input logic                       log_ready,
    input logic                       out_valid,
    input logic                       idle,
    input clog_pkg::clog_state_t      st,
    input logic [clog_pkg::FIELD_W-1:0] cnt
);
    localparam int DATA_BYTES = (1 << ADDR_W) - (1 << PAGE_W);
    localparam logic [ADDR_W-1:0] RES_BASE = ADDR_W'(DATA_BYTES);
    localparam logic [clog_pkg::FIELD_W-1:0] DATA_F = clog_pkg::FIELD_W'(DATA_BYTES);

    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R11
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) && !mem_ready |=>
        (mem_rd == $past(mem_rd)) && (mem_wr == $past(mem_wr)) &&
        $stable(mem_addr) && $stable(mem_wdata)); // R11
    AST_RESERVED_META_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr && (mem_addr >= RES_BASE) |-> st == clog_pkg::S_STORE); // R5
    AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= DATA_F); // R7
    AST_OUT_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(mem_rd && mem_ready)); // R8
    AST_QUIET_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
        (idle || log_ready) |-> !(mem_rd || mem_wr)); // R10
endmodule

bind circ_log_ctrl clog_checker #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready),
    .log_ready (log_ready),
    .out_valid (out_valid),
    .idle      (idle),
    .st        (state),
    .cnt       (sess_cnt)
);

// File: tb/circ_log_ctrl_bench.sv
// Directed bench for the circular log controller: a small 4-page memory model
// with adjustable latency, one task per scenario.
module circ_log_ctrl_bench;
    localparam int AW   = 10;
    localparam int PW   = 8;
    localparam int MEMN = 1 << AW;
    localparam int RES  = MEMN - (1 << PW);
    localparam int DATA = RES;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_req = 1'b0, end_req = 1'b0, replay_req = 1'b0;
    logic log_valid = 1'b0;
    logic [7:0] log_data = 8'h00;
    logic log_ready, out_valid, idle, mem_rd, mem_wr;
    logic [7:0] out_data, mem_wdata;
    logic [7:0] mem_rdata;
    logic [AW-1:0] mem_addr;
    logic mem_ready;

    int total = 0;
    int bad = 0;
    int lat = 1;

    // memory model state
    logic [7:0] mem [0:MEMN-1];
    logic       pre_we = 1'b0, pre_clr = 1'b0;
    logic [AW-1:0] pre_addr = '0;
    logic [7:0] pre_data = 8'h00;
    int wcnt;
    int rd_n, wr_n, viol;
    int rd_log [0:2047];
    logic [7:0] rx [0:2047];
    int rx_n = 0;
    logic p_req, p_rdy, p_rd;
    logic [AW-1:0] p_addr;
    logic [7:0] p_wd;

    always #10 clk = ~clk;

    circ_log_ctrl #(.ADDR_W(AW), .PAGE_W(PW)) u_circ_log_ctrl (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .end_req(end_req),
        .replay_req(replay_req), .log_valid(log_valid), .log_data(log_data),
        .log_ready(log_ready), .out_valid(out_valid), .out_data(out_data),
        .idle(idle), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    // Memory model: one access at a time, ready after lat wait cycles.
    always @(posedge clk) begin
        if (pre_clr) begin
            for (int i = 0; i < MEMN; i++) mem[i] <= 8'hFF;
        end else if (pre_we) begin
            mem[pre_addr] <= pre_data;
        end
        if (!rst_n) begin
            mem_ready <= 1'b0; wcnt <= 0; rd_n <= 0; wr_n <= 0; mem_rdata <= 8'h00;
        end else if ((mem_rd || mem_wr) && !mem_ready) begin
            if (wcnt >= lat) begin
                mem_ready <= 1'b1;
                wcnt <= 0;
                mem_rdata <= mem[mem_addr];
                if (mem_wr) begin
                    mem[mem_addr] <= mem_wdata;
                    wr_n <= wr_n + 1;
                end else begin
                    if (rd_n < 2048) rd_log[rd_n] <= int'(mem_addr);
                    rd_n <= rd_n + 1;
                end
            end else begin
                wcnt <= wcnt + 1;
            end
        end else begin
            mem_ready <= 1'b0;
        end
    end

    // Handshake monitor: a pending request must not change before ready.
    always @(posedge clk) begin
        if (!rst_n) begin
            p_req <= 1'b0; p_rdy <= 1'b0; p_rd <= 1'b0; p_addr <= '0; p_wd <= '0; viol <= 0;
        end else begin
            if (p_req && !p_rdy &&
                (!(mem_rd || mem_wr) || mem_rd != p_rd || mem_addr != p_addr ||
                 (mem_wr && mem_wdata != p_wd)))
                viol <= viol + 1;
            if (mem_rd && mem_wr) viol <= viol + 1;
            p_req <= mem_rd || mem_wr; p_rdy <= mem_ready; p_rd <= mem_rd;
            p_addr <= mem_addr; p_wd <= mem_wdata;
        end
    end

    // Replay collector, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (rx_n < 2048) rx[rx_n] = out_data;
            rx_n = rx_n + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic int fld(input int k);
        return int'({mem[RES+3*k], mem[RES+3*k+1], mem[RES+3*k+2]});
    endfunction

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 7 + 3) & 255);
    endfunction

    task automatic clear_mem();
        @(negedge clk); pre_clr = 1'b1;
        @(negedge clk); pre_clr = 1'b0;
    endtask

    task automatic poke(input int a, input logic [7:0] d);
        @(negedge clk); pre_we = 1'b1; pre_addr = AW'(a); pre_data = d;
        @(negedge clk); pre_we = 1'b0;
    endtask

    task automatic set_meta(input int rs, input int ws, input int cn);
        logic [23:0] v [0:2];
        v[0] = 24'(rs); v[1] = 24'(ws); v[2] = 24'(cn);
        for (int k = 0; k < 3; k++)
            for (int b = 0; b < 3; b++)
                poke(RES + 3*k + b, v[k][23-8*b -: 8]);
    endtask

    task automatic pulse_start();
        @(negedge clk); start_req = 1'b1;
        @(negedge clk); start_req = 1'b0;
    endtask

    task automatic do_start();
        pulse_start();
        while (!log_ready) @(negedge clk);
    endtask

    task automatic log_byte(input logic [7:0] b);
        @(negedge clk); log_valid = 1'b1; log_data = b;
        @(negedge clk); log_valid = 1'b0;
        while (!log_ready) @(negedge clk);
    endtask

    task automatic do_end();
        @(negedge clk); end_req = 1'b1;
        @(negedge clk); end_req = 1'b0;
        while (!idle) @(negedge clk);
    endtask

    task automatic do_replay(output int base, output int got);
        base = rx_n;
        @(negedge clk); replay_req = 1'b1;
        @(negedge clk); replay_req = 1'b0;
        while (!idle) @(negedge clk);
        repeat (3) @(negedge clk);
        got = rx_n - base;
    endtask

    task automatic t_reset();
        chk("R1 idle", int'(idle), 1);
        chk("R1 log_ready", int'(log_ready), 0);
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 mem_rd", int'(mem_rd), 0);
        chk("R1 mem_wr", int'(mem_wr), 0);
    endtask

    task automatic t_first_session();
        int rb;
        lat = 1;
        clear_mem();
        rb = rd_n;
        do_start();
        chk("R2 meta read count", rd_n - rb, 9);
        for (int i = 0; i < 9; i++) chk("R2 meta read addr", rd_log[rb+i], RES + i);
        for (int i = 0; i < 5; i++) log_byte(8'hA0 + 8'(i));
        for (int i = 0; i < 5; i++) chk("R3 first-use data", int'(mem[i]), 8'hA0 + i);
        do_end();
        chk("R6 read-start", fld(0), 0);
        chk("R6 write-start", fld(1), 5);
        chk("R6 count", fld(2), 5);
    endtask

    task automatic t_ignored_and_resume();
        int rb, wb;
        lat = 2;
        rb = rd_n; wb = wr_n;
        @(negedge clk); end_req = 1'b1;
        @(negedge clk); end_req = 1'b0;
        repeat (6) @(negedge clk);
        chk("R10 end in idle reads", rd_n - rb, 0);
        chk("R10 end in idle writes", wr_n - wb, 0);
        chk("R10 end in idle state", int'(idle), 1);
        do_start();
        rb = rd_n;
        @(negedge clk); replay_req = 1'b1; start_req = 1'b1;
        @(negedge clk); replay_req = 1'b0; start_req = 1'b0;
        repeat (6) @(negedge clk);
        chk("R10 req in session reads", rd_n - rb, 0);
        chk("R10 session still open", int'(log_ready), 1);
        for (int i = 0; i < 3; i++) log_byte(8'hB0 + 8'(i));
        for (int i = 0; i < 3; i++) chk("R4 resume data", int'(mem[5+i]), 8'hB0 + i);
        do_end();
        chk("R6 read-start s2", fld(0), 5);
        chk("R6 write-start s2", fld(1), 8);
        chk("R6 count s2", fld(2), 3);
    endtask

    task automatic t_replay_short();
        int base, got;
        lat = 0;
        do_replay(base, got);
        chk("R8 replay length", got, 3);
        for (int i = 0; i < 3; i++) chk("R8 replay byte", int'(rx[base+i]), 8'hB0 + i);
    endtask

    task automatic t_wrap();
        int base, got;
        int exp_a [0:5];
        exp_a = '{765, 766, 767, 0, 1, 2};
        lat = 1;
        set_meta(0, 765, 0);
        do_start();
        for (int i = 0; i < 6; i++) log_byte(8'hC0 + 8'(i));
        for (int i = 0; i < 6; i++) chk("R5 wrap data", int'(mem[exp_a[i]]), 8'hC0 + i);
        do_end();
        chk("R5 reserved byte untouched", int'(mem[RES+9]), 8'hFF);
        chk("R6 read-start wrap", fld(0), 765);
        chk("R5 write-start wrap", fld(1), 3);
        chk("R6 count wrap", fld(2), 6);
        do_replay(base, got);
        chk("R8 wrap replay length", got, 6);
        for (int i = 0; i < 6; i++) chk("R8 wrap replay byte", int'(rx[base+i]), 8'hC0 + i);
    endtask

    task automatic t_saturate();
        int base, got, mism;
        lat = 0;
        set_meta(0, 100, 0);
        do_start();
        for (int i = 0; i < DATA + 2; i++) log_byte(pat(i));
        do_end();
        chk("R7 count saturated", fld(2), DATA);
        chk("R7 read-start moved", fld(0), 102);
        chk("R7 write-start", fld(1), 102);
        do_replay(base, got);
        chk("R7 replay length", got, DATA);
        mism = 0;
        for (int j = 0; j < DATA; j++) if (rx[base+j] !== pat(j+2)) mism++;
        chk("R7 R8 newest bytes in order", mism, 0);
    endtask

    task automatic t_blank_replay();
        int base, got, wb;
        lat = 1;
        clear_mem();
        wb = wr_n;
        do_replay(base, got);
        chk("R9 blank replay output", got, 0);
        chk("R9 blank replay writes", wr_n - wb, 0);
        chk("R9 back to idle", int'(idle), 1);
    endtask

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Scenario sequence.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_session();
        t_ignored_and_resume();
        t_replay_short();
        t_wrap();
        t_saturate();
        t_blank_replay();
        chk("R11 handshake violations", viol, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule